// File: doc/BRIEF.md
# Local Bus Master Transfer Engine

This block is a bus-master engine that copies a programmed number of 32-bit words between a small on-chip user memory and a range of addresses on a simple request/acknowledge local bus. Software supplies four control values: a start level, a direction, a bus base address and a word count. While the start level is high and the engine is idle, the engine latches these values. It then runs one bus cycle per word, reports completion with a one-cycle interrupt pulse, and waits for software to lower the start level before it accepts another operation.

The same user memory can also be reached through a slave-side port. Software can fill it before a write-direction operation and read it back after a read-direction operation. The engine's current state is driven out as a two-bit code so that it can be read back.

The states are IDLE, XFER, DONE and WAIT_CLEAR. Their transitions are:
- IDLE to XFER on start with a non-zero count.
- IDLE to DONE on start with a count of zero.
- XFER to DONE when the last word is acknowledged.
- DONE to WAIT_CLEAR unconditionally after one cycle.
- WAIT_CLEAR to IDLE once the start level is low.

Top module: `lb_xfer_engine`

## Requirements
- R1: After reset the state code is IDLE, `bus_req` is low and `irq_done` is low.
- R2: In IDLE, a high `go` with a non-zero `word_cnt` moves the engine to XFER on the next clock, and the engine begins requesting the bus.
- R3: With `dir_wr`=1, user memory words 0, 1, 2, ... are written to the bus. With `dir_wr`=0, bus words are read into user memory entries 0, 1, 2, ...
- R4: Each word uses one `bus_req` that is held, with a stable address, until `bus_ack`. The first address is `dst_addr`, and each later word's address is 4 higher than the previous one.
- R5: A `word_cnt` of 0 goes from IDLE straight to DONE with no bus request and leaves user memory untouched.
- R6: A `word_cnt` above 16 is clamped to 16 words. No bus location or memory entry beyond the 16th word is touched.
- R7: `irq_done` is high for exactly one cycle per operation, in the cycle the engine is in DONE.
- R8: DONE always moves to WAIT_CLEAR. WAIT_CLEAR holds while `go` is high, with no bus request, and returns to IDLE only once `go` is low.
- R9: `eng_state` reads IDLE=0, XFER=1, DONE=2, WAIT_CLEAR=3.
- R10: The slave port writes entry `sl_idx` on `sl_we` and reads it combinationally on `sl_rdata`.
- R11: Direction, address and count are latched at start. Changing `dir_wr` or `dst_addr` during XFER has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start level |
| dir_wr | input | 1 | 1 = memory to bus, 0 = bus to memory |
| dst_addr | input | 32 | Bus base address |
| word_cnt | input | 8 | Number of words to move |
| sl_we | input | 1 | Slave write enable to user memory |
| sl_idx | input | 4 | Slave word index |
| sl_wdata | input | 32 | Slave write data |
| sl_rdata | output | 32 | Slave read data |
| bus_req | output | 1 | Bus cycle request |
| bus_wr | output | 1 | Bus cycle is a write |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| bus_ack | input | 1 | Bus cycle acknowledge |
| eng_state | output | 2 | Current state code |
| irq_done | output | 1 | Completion pulse |

## Verification
A table of operations covers both directions with several patterns:
- Counts of 1, 3, 4 and exactly 16, which confirm that the word count and the address stepping end on the right word.
- Counts of 20 and 200, which show that clamping stops at 16 and leaves the following location untouched.
- A count of 0, which separates the direct IDLE-to-DONE path from a transfer of one word.

Acknowledge latencies from zero to three wait cycles show whether the request is held and the address stays stable while the engine waits. A high base address checks that address stepping carries across the upper bits. Holding `go` high after completion separates a level-sensitive engine that re-arms from one that would restart. Changing the inputs mid-transfer shows that the latched copies, not the live inputs, drive the bus.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_XFER       = 2'd1,
        ST_DONE       = 2'd2,
        ST_WAIT_CLEAR = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/xfer_umem.sv
module xfer_umem #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          sl_we,
    input  logic [IW-1:0] sl_idx,
    input  logic [DW-1:0] sl_wdata,
    output logic [DW-1:0] sl_rdata,
    input  logic          en_we,
    input  logic [IW-1:0] en_idx,
    input  logic [DW-1:0] en_wdata,
    output logic [DW-1:0] en_rdata
);
    logic [DW-1:0] words [DEPTH];

    // One register per word; the engine port wins a same-cycle collision.
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (en_we && en_idx == IW'(g))
                words[g] <= en_wdata;
            else if (sl_we && sl_idx == IW'(g))
                words[g] <= sl_wdata;
        end
    end

    assign sl_rdata = words[sl_idx];
    assign en_rdata = words[en_idx];
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import xfer_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int CW    = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          dir_wr,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] word_cnt,
    input  logic          bus_ack,
    output xfer_state_e   state_o,
    output logic          bus_req,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [IW-1:0] mem_idx,
    output logic          mem_we,
    output logic          irq_done
);
    xfer_state_e   state_q, state_d;
    logic          dir_q;
    logic [AW-1:0] addr_q;
    logic [IW-1:0] idx_q;
    logic [LW-1:0] left_q;
    logic [LW-1:0] clamped;

    assign clamped = (word_cnt > CW'(DEPTH)) ? LW'(DEPTH) : LW'(word_cnt);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go)
                    state_d = (clamped == '0) ? ST_DONE : ST_XFER;
            end
            ST_XFER: begin
                if (bus_ack && left_q == LW'(1))
                    state_d = ST_DONE;
            end
            ST_DONE:       state_d = ST_WAIT_CLEAR;
            ST_WAIT_CLEAR: begin
                if (!go)
                    state_d = ST_IDLE;
            end
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Operation registers: latched at start, stepped per acknowledged word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            addr_q <= '0;
            idx_q  <= '0;
            left_q <= '0;
        end else if (state_q == ST_IDLE && go) begin
            dir_q  <= dir_wr;
            addr_q <= base_addr;
            idx_q  <= '0;
            left_q <= clamped;
        end else if (state_q == ST_XFER && bus_ack) begin
            addr_q <= addr_q + AW'(4);
            idx_q  <= idx_q + IW'(1);
            left_q <= left_q - LW'(1);
        end
    end

    // Outputs
    always_comb begin
        bus_req  = 1'b0;
        bus_wr   = 1'b0;
        mem_we   = 1'b0;
        irq_done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                bus_req = 1'b1;
                bus_wr  = dir_q;
                mem_we  = bus_ack && !dir_q;
            end
            ST_DONE:       irq_done = 1'b1;
            ST_WAIT_CLEAR: ;
            default: ;
        endcase
    end

    assign bus_addr = addr_q;
    assign mem_idx  = idx_q;
    assign state_o  = state_q;

    // Assertions
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && go && word_cnt != '0) |=> state_q == ST_XFER);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr)));
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req || bus_addr == $past(bus_addr) + AW'(4)));
    p_zero_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && go && word_cnt == '0) |=> (state_q == ST_DONE && !bus_req));
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |-> (left_q != '0 && left_q <= LW'(DEPTH)));
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);
    p_done_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> state_q == ST_WAIT_CLEAR);
    p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_CLEAR && go) |=> (state_q == ST_WAIT_CLEAR && !bus_req));
    p_latched_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(bus_wr));
endmodule

// File: rtl/lb_xfer_engine.sv
module lb_xfer_engine
    import xfer_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int CW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          dir_wr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] word_cnt,
    input  logic          sl_we,
    input  logic [IW-1:0] sl_idx,
    input  logic [DW-1:0] sl_wdata,
    output logic [DW-1:0] sl_rdata,
    output logic          bus_req,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic [1:0]    eng_state,
    output logic          irq_done
);
    xfer_state_e   st;
    logic [IW-1:0] m_idx;
    logic          m_we;
    logic          req_i;

    xfer_fsm #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .dir_wr    (dir_wr),
        .base_addr (dst_addr),
        .word_cnt  (word_cnt),
        .bus_ack   (bus_ack),
        .state_o   (st),
        .bus_req   (req_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .mem_idx   (m_idx),
        .mem_we    (m_we),
        .irq_done  (irq_done)
    );

    xfer_umem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk      (clk),
        .sl_we    (sl_we),
        .sl_idx   (sl_idx),
        .sl_wdata (sl_wdata),
        .sl_rdata (sl_rdata),
        .en_we    (m_we),
        .en_idx   (m_idx),
        .en_wdata (bus_rdata),
        .en_rdata (bus_wdata)
    );

    assign bus_req   = req_i;
    assign eng_state = st;

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (eng_state == 2'd0 && !bus_req && !irq_done));
endmodule

// File: tb/sim_lb_xfer_engine.sv
module sim_lb_xfer_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0, dir_wr = 1'b0;
    logic [31:0] dst_addr = '0;
    logic [7:0]  word_cnt = '0;
    logic        sl_we = 1'b0;
    logic [3:0]  sl_idx = '0;
    logic [31:0] sl_wdata = '0, sl_rdata;
    logic        bus_req, bus_wr, bus_ack = 1'b0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic [1:0]  eng_state;
    logic        irq_done;

    always #4 clk = ~clk;

    lb_xfer_engine u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .dir_wr(dir_wr), .dst_addr(dst_addr),
        .word_cnt(word_cnt), .sl_we(sl_we), .sl_idx(sl_idx), .sl_wdata(sl_wdata),
        .sl_rdata(sl_rdata), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .eng_state(eng_state), .irq_done(irq_done)
    );

    int checks = 0, fails = 0;
    logic [31:0] bmem [64];
    int lat = 0, wcnt = 0;
    int words = 0, writes = 0, irqs = 0, addr_err = 0;
    logic [31:0] mon_base = '0;

    // {dir, addr, count, latency}
    localparam logic [44:0] VEC [8] = '{
        {1'b1, 32'h0000_1000, 8'd4,   4'd0},
        {1'b0, 32'h0000_2040, 8'd3,   4'd2},
        {1'b1, 32'h8000_00F0, 8'd16,  4'd1},
        {1'b0, 32'h0000_0400, 8'd16,  4'd0},
        {1'b1, 32'h0000_0010, 8'd1,   4'd3},
        {1'b0, 32'h0000_0020, 8'd20,  4'd0},
        {1'b1, 32'h0000_0040, 8'd200, 4'd1},
        {1'b0, 32'h0000_0080, 8'd0,   4'd0}
    };

    // Bus responder and monitors, all at the falling edge
    always @(negedge clk) begin
        if (irq_done) irqs++;
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (wcnt >= lat) begin
                if (bus_addr != mon_base + 32'(4 * words)) addr_err++;
                bus_rdata = bmem[bus_addr[7:2]];
                if (bus_wr) begin
                    bmem[bus_addr[7:2]] = bus_wdata;
                    writes++;
                end
                words++;
                wcnt = 0;
                bus_ack = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_umem(input int v);
        for (int i = 0; i < 16; i++) begin
            sl_we = 1'b1; sl_idx = 4'(i);
            sl_wdata = 32'hA000_0000 | (32'(v) << 8) | 32'(i);
            tick();
        end
        sl_we = 1'b0;
    endtask

    function automatic logic [31:0] bpat(input int v, input int k);
        return 32'hB000_0000 | (32'(v) << 8) | 32'(k);
    endfunction

    task automatic wait_state(input logic [1:0] s, output bit ok);
        ok = 1'b0;
        for (int c = 0; c < 2000; c++) begin
            if (eng_state == s) begin ok = 1'b1; break; end
            tick();
        end
    endtask

    task automatic run_vec(input int v, input logic [44:0] e);
        logic        d;
        logic [31:0] a;
        int          n, base_i, bad;
        bit          ok;
        d = e[44]; a = e[43:12]; n = (e[11:4] > 16) ? 16 : int'(e[11:4]);
        for (int k = 0; k < 64; k++) bmem[k] = bpat(v, k);
        fill_umem(v);
        lat = int'(e[3:0]); words = 0; writes = 0; irqs = 0; addr_err = 0; mon_base = a;
        dir_wr = d; dst_addr = a; word_cnt = e[11:4]; go = 1'b1;
        wait_state(2'd3, ok);
        check("R8 reached WAIT_CLEAR", 32'(ok), 32'd1);
        check("R4/R5/R6 word count", 32'(words), 32'(n));
        check("R4 address sequence errors", 32'(addr_err), 32'd0);
        check("R7 one irq pulse", 32'(irqs), 32'd1);
        check("R3 bus writes match direction", 32'(writes), d ? 32'(n) : 32'd0);
        repeat (5) tick();
        check("R8 holds while go high", 32'(eng_state), 32'd3);
        check("R8 no restart while go high", 32'(words), 32'(n));
        go = 1'b0;
        tick(); tick();
        check("R8/R9 back to IDLE", 32'(eng_state), 32'd0);
        base_i = int'(a[7:2]);
        bad = 0;
        if (d) begin
            for (int i = 0; i < 64; i++) begin
                int off = (i - base_i + 64) % 64;
                logic [31:0] ex = (off < n) ? (32'hA000_0000 | (32'(v) << 8) | 32'(off))
                                            : bpat(v, i);
                if (bmem[i] !== ex) bad++;
            end
            check("R3/R6 bus contents after memory-to-bus", 32'(bad), 32'd0);
        end else begin
            for (int i = 0; i < 16; i++) begin
                logic [31:0] ex = (i < n) ? bpat(v, (base_i + i) % 64)
                                          : (32'hA000_0000 | (32'(v) << 8) | 32'(i));
                sl_idx = 4'(i); #1;
                if (sl_rdata !== ex) bad++;
            end
            check("R3/R5/R6 memory contents after bus-to-memory", 32'(bad), 32'd0);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ok;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 / R9 reset state
        check("R1 state after reset", 32'(eng_state), 32'd0);
        check("R1 no request after reset", 32'(bus_req), 32'd0);
        check("R1 no irq after reset", 32'(irq_done), 32'd0);

        // R10 slave port
        sl_we = 1'b1; sl_idx = 4'd7; sl_wdata = 32'hDEAD_BEEF; tick();
        sl_we = 1'b0; sl_idx = 4'd7; #1;
        check("R10 slave read back", sl_rdata, 32'hDEAD_BEEF);

        for (int v = 0; v < 8; v++) run_vec(v, VEC[v]);

        // R11: inputs changed mid-transfer do not affect the running operation
        for (int k = 0; k < 64; k++) bmem[k] = bpat(9, k);
        fill_umem(9);
        lat = 3; words = 0; writes = 0; irqs = 0; addr_err = 0; mon_base = 32'h0000_0300;
        dir_wr = 1'b0; dst_addr = 32'h0000_0300; word_cnt = 8'd4; go = 1'b1;
        tick();
        // R2 / R9: XFER code one clock after start
        check("R2/R9 XFER after start", 32'(eng_state), 32'd1);
        dir_wr = 1'b1; dst_addr = 32'hFFFF_0000; word_cnt = 8'd9;
        wait_state(2'd3, ok);
        check("R11 words from latched count", 32'(words), 32'd4);
        check("R11 no writes after direction change", 32'(writes), 32'd0);
        check("R11 addresses from latched base", 32'(addr_err), 32'd0);
        sl_idx = 4'd3; #1;
        check("R11 read data landed in memory", sl_rdata, bpat(9, 3));
        go = 1'b0; tick(); tick();

        // R5: zero count takes no bus cycle and goes straight to DONE
        words = 0; irqs = 0;
        word_cnt = 8'd0; go = 1'b1;
        tick();
        check("R5 DONE right after zero-count start", 32'(eng_state), 32'd2);
        check("R7 irq high in DONE", 32'(irq_done), 32'd1);
        tick();
        check("R7 irq gone after DONE", 32'(irq_done), 32'd0);
        check("R5 no bus words", 32'(words), 32'd0);
        go = 1'b0; tick(); tick();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule